// File: doc/BRIEF.md
# T1 Receive Channel Timing Generator

This block produces the per-channel and per-frame timing strobes for the receive side of a T1 framer. Upstream logic has already found frame alignment. Each frame it supplies a one-clock frame-start strobe, together with the received framing bit and the 1-based frame number within the multiframe. From these inputs the block keeps its own bit position across the 193-bit frame. A frame is one framing bit, then 24 channels of 8 bits each, with the MSB of each channel first.

There are three outputs. The first pin carries either a channel clock or a link clock. The second pin carries either a per-channel block strobe or link data. One select input switches both pins together. The third output is a frame sync pulse, which can be made two clocks wide on signaling frames. A 24-bit mask register sets which channels the block strobe marks. All outputs are registered and change only on rising edges of the receive clock.

Top module: `rct_rx_timing`

## Requirements
- R1: A high `frame_start` in clock cycle t marks bit position 0, the framing bit. Later cycles are positions 1 to 192, and channel k (1 to 24) occupies positions 8k-7 to 8k. The outputs for the position presented in cycle t appear in cycle t+1.
- R2: After reset, and until the first `frame_start`, all three outputs are low and the mask is all zeros.
- R3: With `link_sel`=0, `chclk_lclk` is high only at positions 8, 16, ... 192, which are the LSBs of the channels. That gives 24 one-clock pulses per frame.
- R4: With `link_sel`=0, `chblk_ldat` equals `mask_q[k-1]` for all 8 positions of channel k. Mask bit 0 belongs to channel 1. The output is low on the framing bit.
- R5: A high `mask_we` loads `mask_d` into the mask at that clock edge. The new mask governs every position presented after that edge.
- R6: `rx_fsync` is high for exactly one clock, at position 0 of each frame.
- R7: With `fs_dbl`=1, `rx_fsync` also stays high at position 1 on signaling frames, which makes a two-clock pulse. Signaling frames are frame numbers 6 and 12 when `fmode`=0, and 6, 12, 18 and 24 for any other `fmode`.
- R8: `fmode` selects which frames carry a link bit. The `fmode` encoding is 0 = 12-frame superframe, 1 = extended superframe, 2 = ZBTSI and 3 = same as 1. The link frames are the even frame numbers for 0, the odd frame numbers for 1 and 3, and frame numbers with value mod 4 equal to 1 for 2. `frame_num` and `frame_bit` are sampled in the `frame_start` cycle.
- R9: With `link_sel`=1, the link state changes at position 192 of each frame, one clock before the next sync pulse. On a link frame, `chblk_ldat` takes that frame's framing bit and `chclk_lclk` goes high. On any other frame, `chclk_lclk` goes low and the data holds. This gives a 4 kHz link clock in modes 1 and 3 and a 2 kHz link clock in mode 2.
- R10: If `frame_start` is not high in the cycle after position 192, all outputs go low and stay low until the next `frame_start`.
- R11: `link_sel` switches both pins together between the channel functions and the link functions. The link state keeps updating whichever function is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | High during the framing-bit cycle of each frame |
| frame_num | input | 5 | 1-based frame number in the multiframe, sampled with frame_start |
| frame_bit | input | 1 | Received framing bit, sampled with frame_start |
| fmode | input | 2 | Framing mode: 0 superframe, 1/3 extended superframe, 2 ZBTSI |
| link_sel | input | 1 | 0 selects the channel functions, 1 selects the link functions |
| fs_dbl | input | 1 | Makes the sync pulse two clocks wide on signaling frames |
| mask_we | input | 1 | Mask write strobe |
| mask_d | input | 24 | Mask write data, bit 0 = channel 1 |
| chclk_lclk | output | 1 | Channel clock or link clock |
| chblk_ldat | output | 1 | Channel block strobe or link data |
| rx_fsync | output | 1 | Receive frame sync pulse |

## Verification
The embedded properties are evaluated on every cycle. They check the following:
- the bit position never runs past the last bit;
- a channel-clock pulse only ever lands on a channel LSB;
- the sync pulse always follows a frame start and never exceeds two clocks;
- the link data changes only at the last bit of a frame;
- a mask write lands on the next edge;
- every output goes quiet once alignment is lost.

Other behaviours need the bench's frame sequences to show them:
- the exact channel positions the mask marks;
- which frame numbers count as signaling frames in each mode;
- the link-frame selection that sets the 4 kHz and 2 kHz link-clock rates;
- recovery after a frame start goes missing;
- a reset in the middle of a frame.

// File: rtl/rct_pkg.sv
package rct_pkg;

  localparam int CHANNELS_DEF = 24;
  localparam int CH_BITS_DEF  = 8;
  localparam int FN_W_DEF     = 5;

  typedef enum logic [1:0] {
    FM_SF    = 2'd0,
    FM_ESF   = 2'd1,
    FM_ZB    = 2'd2,
    FM_ESF_B = 2'd3
  } fmode_e;

  // signaling frames: 6,12 in superframe; 6,12,18,24 otherwise
  function automatic logic is_sig_frame(input int fn, input fmode_e md);
    if (md == FM_SF) return (fn == 6) || (fn == 12);
    return (fn == 6) || (fn == 12) || (fn == 18) || (fn == 24);
  endfunction

  // frames carrying a link bit
  function automatic logic is_link_frame(input int fn, input fmode_e md);
    case (md)
      FM_SF:   return (fn % 2) == 0;
      FM_ZB:   return (fn % 4) == 1;
      default: return (fn % 2) == 1;
    endcase
  endfunction

endpackage

// File: rtl/rct_bitpos.sv
module rct_bitpos #(
  parameter int LAST = 192,
  parameter int PW   = 8,
  parameter int FN_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_start,
  input  logic [FN_W-1:0] frame_num,
  input  logic            frame_bit,
  output logic            sync_c,
  output logic [PW-1:0]   pos_c,
  output logic [FN_W-1:0] fn_c,
  output logic            fb_c
);
  logic [PW-1:0]   cnt_q;
  logic            sync_q;
  logic [FN_W-1:0] fn_q;
  logic            fb_q;

  always_comb begin
    sync_c = frame_start | (sync_q && (cnt_q != PW'(LAST)));
    pos_c  = frame_start ? '0 : cnt_q + 1'b1;
    fn_c   = frame_start ? frame_num : fn_q;
    fb_c   = frame_start ? frame_bit : fb_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sync_q <= 1'b0;
      fn_q   <= '0;
      fb_q   <= 1'b0;
    end else begin
      sync_q <= sync_c;
      fn_q   <= fn_c;
      fb_q   <= fb_c;
      if (sync_c) cnt_q <= pos_c;
    end
  end

  a_r1_pos_range: assert property (@(posedge clk) disable iff (rst)
    sync_q |-> (cnt_q <= PW'(LAST)));

endmodule

// File: rtl/rct_chan.sv
module rct_chan #(
  parameter int CHANNELS = 24,
  parameter int CH_BITS  = 8,
  parameter int PW       = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mask_we,
  input  logic [CHANNELS-1:0] mask_d,
  input  logic [PW-1:0]       pos_c,
  output logic                chclk_n,
  output logic                chblk_n
);
  logic [CHANNELS-1:0] mask_q;
  logic [CHANNELS-1:0] win;
  logic [CHANNELS-1:0] lsb;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    localparam int LO = g * CH_BITS + 1;
    localparam int HI = (g + 1) * CH_BITS;
    assign win[g] = (pos_c >= PW'(LO)) && (pos_c <= PW'(HI));
    assign lsb[g] = (pos_c == PW'(HI));
  end

  assign chclk_n = |lsb;
  assign chblk_n = |(win & mask_q);

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end

  a_r5_mask_load: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> (mask_q == $past(mask_d)));

endmodule

// File: rtl/rct_link.sv
module rct_link
  import rct_pkg::*;
#(
  parameter int LAST = 192,
  parameter int PW   = 8,
  parameter int FN_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sync_c,
  input  logic [PW-1:0]   pos_c,
  input  logic [FN_W-1:0] fn_c,
  input  logic            fb_c,
  input  logic [1:0]      fmode,
  output logic            lclk_n,
  output logic            ldat_n
);
  logic lclk_q, ldat_q, upd, lfr;

  always_comb begin
    upd    = sync_c && (pos_c == PW'(LAST));
    lfr    = is_link_frame(int'(fn_c), fmode_e'(fmode));
    lclk_n = upd ? lfr : lclk_q;
    ldat_n = (upd && lfr) ? fb_c : ldat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lclk_q <= 1'b0;
      ldat_q <= 1'b0;
    end else begin
      lclk_q <= lclk_n;
      ldat_q <= ldat_n;
    end
  end

  a_r9_ldat_hold: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(ldat_q));

endmodule

// File: rtl/rct_rx_timing.sv
module rct_rx_timing
  import rct_pkg::*;
#(
  parameter int CHANNELS = CHANNELS_DEF,
  parameter int CH_BITS  = CH_BITS_DEF,
  parameter int FN_W     = FN_W_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_start,
  input  logic [FN_W-1:0]     frame_num,
  input  logic                frame_bit,
  input  logic [1:0]          fmode,
  input  logic                link_sel,
  input  logic                fs_dbl,
  input  logic                mask_we,
  input  logic [CHANNELS-1:0] mask_d,
  output logic                chclk_lclk,
  output logic                chblk_ldat,
  output logic                rx_fsync
);
  localparam int LAST = CHANNELS * CH_BITS;
  localparam int PW   = $clog2(LAST + 2);

  logic            sync_c, fb_c;
  logic [PW-1:0]   pos_c;
  logic [FN_W-1:0] fn_c;
  logic            chclk_n, chblk_n, lclk_n, ldat_n, fs_n;

  rct_bitpos #(.LAST(LAST), .PW(PW), .FN_W(FN_W)) u_pos (
    .clk(clk), .rst(rst), .frame_start(frame_start), .frame_num(frame_num),
    .frame_bit(frame_bit), .sync_c(sync_c), .pos_c(pos_c), .fn_c(fn_c),
    .fb_c(fb_c)
  );

  rct_chan #(.CHANNELS(CHANNELS), .CH_BITS(CH_BITS), .PW(PW)) u_chan (
    .clk(clk), .rst(rst), .mask_we(mask_we), .mask_d(mask_d), .pos_c(pos_c),
    .chclk_n(chclk_n), .chblk_n(chblk_n)
  );

  rct_link #(.LAST(LAST), .PW(PW), .FN_W(FN_W)) u_link (
    .clk(clk), .rst(rst), .sync_c(sync_c), .pos_c(pos_c), .fn_c(fn_c),
    .fb_c(fb_c), .fmode(fmode), .lclk_n(lclk_n), .ldat_n(ldat_n)
  );

  always_comb begin
    fs_n = sync_c && ((pos_c == '0) ||
           (fs_dbl && (pos_c == PW'(1)) && is_sig_frame(int'(fn_c), fmode_e'(fmode))));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chclk_lclk <= 1'b0;
      chblk_ldat <= 1'b0;
      rx_fsync   <= 1'b0;
    end else begin
      chclk_lclk <= sync_c && (link_sel ? lclk_n : chclk_n);
      chblk_ldat <= sync_c && (link_sel ? ldat_n : chblk_n);
      rx_fsync   <= fs_n;
    end
  end

  a_r3_chclk_lsb: assert property (@(posedge clk) disable iff (rst)
    (chclk_lclk && !$past(link_sel)) |->
      (($past(pos_c) % PW'(CH_BITS)) == '0 && $past(pos_c) != '0));

  a_r6_fs_origin: assert property (@(posedge clk) disable iff (rst)
    rx_fsync |-> ($past(frame_start) || $past(rx_fsync)));

  a_r7_fs_max2: assert property (@(posedge clk) disable iff (rst)
    (rx_fsync && $past(rx_fsync)) |=> !rx_fsync);

  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(sync_c) |-> (!chclk_lclk && !chblk_ldat && !rx_fsync));

endmodule

// File: tb/rct_rx_timing_bench.sv
`timescale 1ns/1ps
module rct_rx_timing_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic [4:0]  frame_num = '0;
  logic        frame_bit = 1'b0;
  logic [1:0]  fmode = '0;
  logic        link_sel = 1'b0;
  logic        fs_dbl = 1'b0;
  logic        mask_we = 1'b0;
  logic [23:0] mask_d = '0;
  logic        chclk_lclk, chblk_ldat, rx_fsync;

  int n_chk = 0;
  int n_err = 0;
  logic e_lclk = 1'b0;
  logic e_ldat = 1'b0;

  always #2 clk = ~clk;

  rct_rx_timing u_rct_rx_timing (
    .clk(clk), .rst(rst), .frame_start(frame_start), .frame_num(frame_num),
    .frame_bit(frame_bit), .fmode(fmode), .link_sel(link_sel), .fs_dbl(fs_dbl),
    .mask_we(mask_we), .mask_d(mask_d), .chclk_lclk(chclk_lclk),
    .chblk_ldat(chblk_ldat), .rx_fsync(rx_fsync)
  );

  // fields: wr[36] mask[35:12] lsel[11] dbl[10] mode[9:8] blk_per_frame[7:0]
  localparam int NSC = 7;
  localparam logic [36:0] SC [NSC] = '{
    {1'b0, 24'h000000, 1'b0, 1'b0, 2'd0, 8'd0},
    {1'b1, 24'hFFFFFF, 1'b0, 1'b1, 2'd0, 8'd192},
    {1'b1, 24'h800001, 1'b0, 1'b1, 2'd1, 8'd16},
    {1'b1, 24'hAAAAAA, 1'b1, 1'b0, 2'd1, 8'd0},
    {1'b0, 24'hAAAAAA, 1'b1, 1'b1, 2'd2, 8'd0},
    {1'b0, 24'hAAAAAA, 1'b1, 1'b1, 2'd0, 8'd0},
    {1'b1, 24'h000F00, 1'b0, 1'b1, 2'd2, 8'd32}
  };

  function automatic bit m_sig(int fn, int mode);
    if (mode == 0) return fn == 6 || fn == 12;
    return (fn % 6) == 0 && fn > 0 && fn <= 24;
  endfunction

  function automatic bit m_link(int fn, int mode);
    if (mode == 0) return !fn[0];
    if (mode == 2) return fn[1:0] == 2'b01;
    return fn[0];
  endfunction

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic chk_int(input int got, input int exp, input string req, input string what);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic idle_quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frame_start = 1'b0;
      @(posedge clk); #1;
      chk(chclk_lclk, 1'b0, req, "pin1 idle");
      chk(chblk_ldat, 1'b0, req, "pin2 idle");
      chk(rx_fsync,   1'b0, req, "fsync idle");
    end
  endtask

  task automatic run_frame(input int fn, input bit fb, input bit lsel, input bit dbl,
                           input int mode, input logic [23:0] m, input int exp_blk);
    int nblk = 0;
    int nclk = 0;
    for (int p = 0; p < 193; p++) begin
      logic e1, e2, e3;
      @(negedge clk);
      frame_start = (p == 0);
      frame_num   = 5'(fn);
      frame_bit   = fb;
      @(posedge clk); #1;
      if (p == 192) begin
        if (m_link(fn, mode)) begin e_ldat = fb; e_lclk = 1'b1; end
        else e_lclk = 1'b0;
      end
      e1 = lsel ? e_lclk : (p > 0 && (p % 8) == 0);
      e2 = lsel ? e_ldat : (p > 0 && m[(p - 1) / 8]);
      e3 = (p == 0) || (dbl && p == 1 && m_sig(fn, mode));
      chk(chclk_lclk, e1, lsel ? "R9 R11" : "R3 R1", $sformatf("pin1 fn %0d pos %0d", fn, p));
      chk(chblk_ldat, e2, lsel ? "R9 R8" : "R4 R1", $sformatf("pin2 fn %0d pos %0d", fn, p));
      chk(rx_fsync, e3, (p == 1) ? "R7" : "R6", $sformatf("fsync fn %0d pos %0d", fn, p));
      nblk += int'(chblk_ldat);
      nclk += int'(chclk_lclk);
    end
    if (!lsel) begin
      chk_int(nclk, 24, "R3", "channel clock pulses per frame");
      chk_int(nblk, exp_blk, "R4 R5", "block cycles per frame");
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(chclk_lclk, 1'b0, "R2", "pin1 after reset");
    chk(chblk_ldat, 1'b0, "R2", "pin2 after reset");
    chk(rx_fsync,   1'b0, "R2", "fsync after reset");
    idle_quiet(3, "R2");

    for (int s = 0; s < NSC; s++) begin
      logic [36:0] v;
      v = SC[s];
      @(negedge clk);
      link_sel = v[11]; fs_dbl = v[10]; fmode = v[9:8];
      if (v[36]) begin
        mask_we = 1'b1; mask_d = v[35:12];
        @(negedge clk); mask_we = 1'b0;
      end
      for (int f = 0; f < 24; f++) begin
        int fn;
        fn = (v[9:8] == 2'd0) ? (f % 12) + 1 : f + 1;
        run_frame(fn, fn[0] ^ fn[2] ^ s[0], v[11], v[10], int'(v[9:8]),
                  (s == 0) ? 24'h0 : v[35:12], int'(v[7:0]));
      end
      idle_quiet(4, "R10");
    end

    // mid-frame reset clears mask and outputs (R2)
    @(negedge clk); link_sel = 1'b0; fs_dbl = 1'b0; fmode = 2'd1;
    mask_we = 1'b1; mask_d = 24'h123456;
    @(negedge clk); mask_we = 1'b0;
    for (int p = 0; p < 40; p++) begin
      @(negedge clk); frame_start = (p == 0); frame_num = 5'd3;
    end
    @(negedge clk); rst = 1'b1; frame_start = 1'b0;
    @(negedge clk); rst = 1'b0;
    e_lclk = 1'b0; e_ldat = 1'b0;
    #1;
    chk(chclk_lclk, 1'b0, "R2", "pin1 after mid reset");
    chk(rx_fsync,   1'b0, "R2", "fsync after mid reset");
    idle_quiet(2, "R2");
    run_frame(5, 1'b1, 1'b0, 1'b0, 1, 24'h0, 0);
    idle_quiet(3, "R10");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule